// File: doc/BRIEF.md
# Multi-level indirect address generator

This block resolves the operand or jump target of a 32-bit accumulator machine. The instruction word carries a 16-bit signed parameter, an index-register selector and four mode flags: indexed, PC-relative, indirect and immediate. The block adds the sign-extended parameter to an optional index register value and an optional program counter value. This sum is the base address.

When the indirect flag is set, the block reads the word at the base address and decodes it again as a fresh address specifier. The opcode byte of that word is ignored. The chain is followed for as long as each fetched word asks for indirection, and there is no depth limit. The immediate flag always comes from the original instruction.

At the end of the chain the result depends on the kind of instruction:
- Jumps and immediate data instructions return the final address.
- Other data instructions read memory once more and return the word found there.

A supervisor can break a runaway chain with the abort input. Memory latency can be anything, because the read request is held until the response arrives.

Top module: `ind_addr_gen`

## Requirements
- R1: After reset, busy, done and mem_rd_en are all 0.
- R2: Field layout of a specifier word: bits 31:24 opcode (ignored), bits 23:20 index selector, bit 19 indexed flag, bit 18 PC-relative flag, bit 17 indirect flag, bit 16 immediate flag, bits 15:0 signed parameter. The base address is the sign-extended parameter, plus the selected index register value when the indexed flag is set, plus the sampled PC when the relative flag is set.
- R3: A data instruction with immediate=1 and indirect=0 returns the base address as the result, performs no memory read, and raises done at the second clock edge after start is sampled.
- R4: A data instruction with immediate=0 performs exactly one read at the final address and returns the word read.
- R5: For a jump instruction (is_jump=1), the immediate flag is ignored and the result is the final address, with no data read.
- R6: When the indirect flag is set, the block reads the word at the base address and recomputes the address from that word's indexed, relative, indirect, selector and parameter fields. This repeats while the fetched word has indirect=1.
- R7: The immediate flag of fetched words is ignored. Only the original instruction's immediate flag selects between returning the address and returning the memory word.
- R8: A self-referencing chain keeps the block busy indefinitely, with no done.
- R9: mem_rd_en and mem_rd_addr stay stable from the cycle a read is issued until mem_rsp_valid is seen, for any latency. No read is issued while idle.
- R10: abort returns the block to idle at the next edge, with no done and no further reads.
- R11: The PC is sampled at start. Changes on the pc input during the calculation have no effect.
- R12: start is ignored while the block is busy.
- R13: done is a single-cycle pulse issued as the block returns to idle, and result is valid while done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a calculation (sampled while idle) |
| abort | input | 1 | Force return to idle |
| instr_word | input | 32 | Instruction word holding flags, selector and parameter |
| is_jump | input | 1 | Instruction is a flow-control instruction |
| pc | input | 32 | Program counter value, sampled at start |
| idx_sel | output | 4 | Index register selector |
| idx_val | input | 32 | Value of the selected index register (combinational) |
| mem_rd_en | output | 1 | Memory read request, held until response |
| mem_rd_addr | output | 32 | Memory read address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | Result valid pulse |
| result | output | 32 | Effective address or operand value |

## Verification
On every cycle, the assertions check the following:
- the read request is held with a stable address until its response (R9), and no read is made while idle;
- abort leaves the block idle and silent at the next edge (R10);
- done is a one-cycle pulse that coincides with idle (R13).

Only the bench scenarios can show the rest. These are the arithmetic of the address modes, the walk through multi-level chains and which immediate flag wins, the use of the sampled PC, the rejection of a start while busy, and the endless self-referencing chain.

// File: rtl/iag_pkg.sv
package iag_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_EVAL = 2'd1,
      ST_PTR  = 2'd2,
      ST_DATA = 2'd3
   } iag_state_e;
endpackage

// File: rtl/iag_field_decode.sv
module iag_field_decode #(
   parameter int DW      = 32,
   parameter int PW      = 16,
   parameter int SELW    = 4,
   parameter int P_BIT   = 19,
   parameter int R_BIT   = 18,
   parameter int I_BIT   = 17,
   parameter int SEL_LSB = 20
) (
   input  logic [DW-1:0]   word,
   output logic            f_idx,
   output logic            f_rel,
   output logic            f_ind,
   output logic [SELW-1:0] sel,
   output logic [DW-1:0]   param_ext
);
   localparam int SEL_MSB = SEL_LSB + SELW - 1;

   logic unused_word;
   assign unused_word = ^word;

   assign f_idx = word[P_BIT];
   assign f_rel = word[R_BIT];
   assign f_ind = word[I_BIT];
   assign sel   = word[SEL_MSB:SEL_LSB];

   generate
      if (PW < DW) begin : g_sext
         assign param_ext = {{(DW-PW){word[PW-1]}}, word[PW-1:0]};
      end else begin : g_full
         assign param_ext = word[DW-1:0];
      end
   endgenerate
endmodule

// File: rtl/iag_base_calc.sv
module iag_base_calc #(
   parameter int DW = 32
) (
   input  logic [DW-1:0] param_ext,
   input  logic [DW-1:0] idx_val,
   input  logic [DW-1:0] pc_val,
   input  logic          use_idx,
   input  logic          use_pc,
   output logic [DW-1:0] base
);
   logic [DW-1:0] idx_term;
   logic [DW-1:0] pc_term;

   assign idx_term = use_idx ? idx_val : '0;
   assign pc_term  = use_pc  ? pc_val  : '0;
   assign base     = param_ext + idx_term + pc_term;
endmodule

// File: rtl/iag_ctrl.sv
module iag_ctrl
   import iag_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          abort,
   input  logic          is_jump,
   input  logic          n_flag,
   input  logic [DW-1:0] instr_word,
   input  logic [DW-1:0] pc,
   input  logic          f_ind,
   input  logic [DW-1:0] base,
   input  logic          mem_rsp_valid,
   input  logic [DW-1:0] mem_rsp_data,
   output logic [DW-1:0] cur_word,
   output logic [DW-1:0] pc_q,
   output logic          mem_rd_en,
   output logic [DW-1:0] mem_rd_addr,
   output logic          busy,
   output logic          done,
   output logic [DW-1:0] result
);
   iag_state_e state;
   logic       imm_q;
   logic       jmp_q;

   assign busy = (state != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         cur_word    <= '0;
         pc_q        <= '0;
         imm_q       <= 1'b0;
         jmp_q       <= 1'b0;
         mem_rd_en   <= 1'b0;
         mem_rd_addr <= '0;
         done        <= 1'b0;
         result      <= '0;
      end else if (abort) begin
         state     <= ST_IDLE;
         mem_rd_en <= 1'b0;
         done      <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  cur_word <= instr_word;
                  pc_q     <= pc;
                  imm_q    <= n_flag;
                  jmp_q    <= is_jump;
                  state    <= ST_EVAL;
               end
            end
            ST_EVAL: begin
               if (f_ind) begin
                  mem_rd_addr <= base;
                  mem_rd_en   <= 1'b1;
                  state       <= ST_PTR;
               end else if (jmp_q || imm_q) begin
                  result <= base;
                  done   <= 1'b1;
                  state  <= ST_IDLE;
               end else begin
                  mem_rd_addr <= base;
                  mem_rd_en   <= 1'b1;
                  state       <= ST_DATA;
               end
            end
            ST_PTR: begin
               if (mem_rsp_valid) begin
                  cur_word  <= mem_rsp_data;
                  mem_rd_en <= 1'b0;
                  state     <= ST_EVAL;
               end
            end
            ST_DATA: begin
               if (mem_rsp_valid) begin
                  result    <= mem_rsp_data;
                  mem_rd_en <= 1'b0;
                  done      <= 1'b1;
                  state     <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/ind_addr_gen.sv
module ind_addr_gen #(
   parameter int DW      = 32,
   parameter int PW      = 16,
   parameter int SELW    = 4,
   parameter int P_BIT   = 19,
   parameter int R_BIT   = 18,
   parameter int I_BIT   = 17,
   parameter int N_BIT   = 16,
   parameter int SEL_LSB = 20
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            abort,
   input  logic [DW-1:0]   instr_word,
   input  logic            is_jump,
   input  logic [DW-1:0]   pc,
   output logic [SELW-1:0] idx_sel,
   input  logic [DW-1:0]   idx_val,
   output logic            mem_rd_en,
   output logic [DW-1:0]   mem_rd_addr,
   input  logic            mem_rsp_valid,
   input  logic [DW-1:0]   mem_rsp_data,
   output logic            busy,
   output logic            done,
   output logic [DW-1:0]   result
);
   localparam int SEL_MSB = SEL_LSB + SELW - 1;

   generate
      if (PW < 2 || PW > DW) begin : g_bad_pw
         $error("ind_addr_gen: PW must lie in 2..DW");
      end
      if (SEL_MSB >= DW) begin : g_bad_sel
         $error("ind_addr_gen: selector field exceeds word");
      end
      if (P_BIT >= DW || R_BIT >= DW || I_BIT >= DW || N_BIT >= DW) begin : g_bad_flag
         $error("ind_addr_gen: flag bit outside word");
      end
      if (P_BIT < PW || R_BIT < PW || I_BIT < PW || N_BIT < PW) begin : g_bad_ovl
         $error("ind_addr_gen: flag bit overlaps parameter field");
      end
   endgenerate

   logic [DW-1:0] cur_word;
   logic [DW-1:0] pc_q;
   logic          f_idx;
   logic          f_rel;
   logic          f_ind;
   logic [DW-1:0] param_ext;
   logic [DW-1:0] base;

   iag_field_decode #(
      .DW(DW), .PW(PW), .SELW(SELW),
      .P_BIT(P_BIT), .R_BIT(R_BIT), .I_BIT(I_BIT), .SEL_LSB(SEL_LSB)
   ) u_dec (
      .word      (cur_word),
      .f_idx     (f_idx),
      .f_rel     (f_rel),
      .f_ind     (f_ind),
      .sel       (idx_sel),
      .param_ext (param_ext)
   );

   iag_base_calc #(.DW(DW)) u_base (
      .param_ext (param_ext),
      .idx_val   (idx_val),
      .pc_val    (pc_q),
      .use_idx   (f_idx),
      .use_pc    (f_rel),
      .base      (base)
   );

   iag_ctrl #(.DW(DW)) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .start         (start),
      .abort         (abort),
      .is_jump       (is_jump),
      .n_flag        (instr_word[N_BIT]),
      .instr_word    (instr_word),
      .pc            (pc),
      .f_ind         (f_ind),
      .base          (base),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_data  (mem_rsp_data),
      .cur_word      (cur_word),
      .pc_q          (pc_q),
      .mem_rd_en     (mem_rd_en),
      .mem_rd_addr   (mem_rd_addr),
      .busy          (busy),
      .done          (done),
      .result        (result)
   );
endmodule

// File: rtl/iag_chk.sv
module iag_chk #(
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          abort,
   input logic          busy,
   input logic          done,
   input logic          mem_rd_en,
   input logic [DW-1:0] mem_rd_addr,
   input logic          mem_rsp_valid
);
   // R9
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_en && !mem_rsp_valid && !abort) |=> (mem_rd_en && $stable(mem_rd_addr)));

   // R9
   idle_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_rd_en);

   // R10
   abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> (!busy && !done && !mem_rd_en));

   // R13
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R13
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
endmodule

bind ind_addr_gen iag_chk #(.DW(DW)) u_iag_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .abort         (abort),
   .busy          (busy),
   .done          (done),
   .mem_rd_en     (mem_rd_en),
   .mem_rd_addr   (mem_rd_addr),
   .mem_rsp_valid (mem_rsp_valid)
);

// File: tb/ind_addr_gen_test.sv
`timescale 1ns/1ps
module ind_addr_gen_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        abort = 1'b0;
   logic [31:0] instr_word = '0;
   logic        is_jump = 1'b0;
   logic [31:0] pc = '0;
   logic [3:0]  idx_sel;
   logic [31:0] idx_val;
   logic        mem_rd_en;
   logic [31:0] mem_rd_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        busy;
   logic        done;
   logic [31:0] result;

   always #10 clk = ~clk;

   ind_addr_gen uut (
      .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
      .instr_word(instr_word), .is_jump(is_jump), .pc(pc),
      .idx_sel(idx_sel), .idx_val(idx_val),
      .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .busy(busy), .done(done), .result(result)
   );

   int tests = 0;
   int fails = 0;
   int reads = 0;
   int lat = 0;
   int cnt = 0;
   bit track = 1'b1;
   bit armed = 1'b0;
   logic [31:0] mem [256];
   logic [31:0] regs [16];
   logic [31:0] exp_q [$];

   assign idx_val = regs[idx_sel];

   // memory model: responds after lat cycles of held request
   always @(posedge clk) begin
      if (!mem_rd_en) begin
         cnt <= 0; mem_rsp_valid <= 1'b0;
      end else if (mem_rsp_valid) begin
         cnt <= 0; mem_rsp_valid <= 1'b0;
      end else if (cnt >= lat) begin
         mem_rsp_valid <= 1'b1;
         mem_rsp_data  <= mem[mem_rd_addr[7:0]];
      end else begin
         cnt <= cnt + 1;
      end
   end

   // per-clock comparison against the expected read sequence
   logic        prev_en = 1'b0;
   logic        prev_rsp = 1'b0;
   logic [31:0] prev_addr = '0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_rd_en && (!prev_en || prev_rsp)) begin
            reads++;
            if (track) begin
               tests++;
               if (exp_q.size() == 0) begin
                  fails++;
                  $display("FAIL R6: unexpected read addr %h, expected none", mem_rd_addr);
               end else begin
                  logic [31:0] e;
                  e = exp_q.pop_front();
                  if (mem_rd_addr !== e) begin
                     fails++;
                     $display("FAIL R6: read addr %h, expected %h", mem_rd_addr, e);
                  end
               end
            end
         end else if (mem_rd_en && mem_rd_addr !== prev_addr) begin
            fails++;
            $display("FAIL R9: addr moved to %h, expected %h", mem_rd_addr, prev_addr);
         end
         if (done && !armed) begin
            fails++;
            $display("FAIL R13: done=%b, expected 0", done);
         end
      end
      prev_en = mem_rd_en; prev_rsp = mem_rsp_valid; prev_addr = mem_rd_addr;
   end

   function automatic logic [31:0] mk(input logic [7:0] opc, input bit p, input bit r,
                                      input bit i, input bit n, input logic [3:0] sel,
                                      input logic [15:0] prm);
      return {opc, sel, p, r, i, n, prm};
   endfunction

   // behavioural reference: walks the chain, queues expected reads
   function automatic logic [31:0] walk(input logic [31:0] w0, input bit jmp, input logic [31:0] pcv);
      logic [31:0] w = w0;
      logic [31:0] b;
      for (int k = 0; k < 64; k++) begin
         b = {{16{w[15]}}, w[15:0]};
         if (w[19]) b = b + regs[w[23:20]];
         if (w[18]) b = b + pcv;
         if (w[17]) begin
            exp_q.push_back(b);
            w = mem[b[7:0]];
         end else if (jmp || w0[16]) begin
            return b;
         end else begin
            exp_q.push_back(b);
            return mem[b[7:0]];
         end
      end
      return 32'hX;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %h, expected %h", tag, act, exp);
      end
   endtask

   task automatic run_op(input string tag, input logic [31:0] w, input bit jmp,
                         input logic [31:0] pcv, input int l, input bit poke, input int exp_cyc);
      logic [31:0] expv;
      int cyc = 0;
      int r0 = reads;
      bit seen = 1'b0;
      expv = walk(w, jmp, pcv);
      @(negedge clk);
      lat = l; instr_word = w; is_jump = jmp; pc = pcv; start = 1'b1; armed = 1'b1;
      @(negedge clk);
      start = 1'b0; pc = 32'hDEAD0000; instr_word = 32'h00FF_FFFF; is_jump = ~jmp;
      cyc = 1;
      while (cyc < 3000 && !seen) begin
         if (done) seen = 1'b1;
         else begin
            @(negedge clk);
            cyc++;
            if (poke && cyc == 3) start = 1'b1;
            else start = 1'b0;
            if (done) seen = 1'b1;
         end
      end
      start = 1'b0;
      check({tag, " done"}, {31'd0, seen}, 32'd1);
      check(tag, result, expv);
      check({tag, " reads left"}, exp_q.size(), 0);
      if (exp_cyc >= 0) begin
         check({tag, " latency"}, cyc, exp_cyc);
         check({tag, " no read"}, reads - r0, 0);
      end
      exp_q.delete();
      @(negedge clk);
      armed = 1'b0;
   endtask

   initial begin
      #(20ns * 150000);
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      for (int k = 0; k < 256; k++) mem[k] = 32'h1000_0000 + k;
      for (int k = 0; k < 16; k++) regs[k] = 32'h100 * k;
      regs[5] = 32'd1000;
      regs[2] = 32'd15;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 busy", {31'd0, busy}, 0);
      check("R1 done", {31'd0, done}, 0);
      check("R1 rd_en", {31'd0, mem_rd_en}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 R3: direct immediate, negative parameter
      run_op("R3 imm neg", mk(8'h11, 0, 0, 0, 1, 0, 16'hFFFD), 0, 32'h40, 0, 0, 2);
      // R2: indexed immediate
      run_op("R2 idx", mk(8'h00, 1, 0, 0, 1, 5, 16'd20), 0, 32'h40, 0, 0, 2);
      // R2: relative immediate
      run_op("R2 rel", mk(8'h00, 0, 1, 0, 1, 0, 16'hFFF0), 0, 32'h100, 0, 0, 2);
      // R2: relative and indexed
      run_op("R2 rel idx", mk(8'h00, 1, 1, 0, 1, 2, 16'd7), 0, 32'h200, 0, 0, 2);
      // R4 R9: single data read, latency 3
      mem[40] = 32'hCAFE_F00D;
      run_op("R4 data", mk(8'h00, 0, 0, 0, 0, 0, 16'd40), 0, 32'h0, 3, 0, -1);
      // R5: jump with immediate clear
      run_op("R5 jump", mk(8'h00, 0, 0, 0, 0, 0, 16'd50), 1, 32'h0, 0, 0, 2);

      // R6 R7 R11: two-level chain, fetched N set and opcode non-zero
      mem[10]  = mk(8'hAB, 1, 0, 1, 1, 2, 16'd5);
      mem[20]  = mk(8'h5C, 0, 1, 0, 1, 0, 16'd4);
      mem[100] = 32'h1234_5678;
      run_op("R6 chain data", mk(8'h00, 0, 0, 1, 0, 0, 16'd10), 0, 32'h60, 2, 0, -1);
      run_op("R7 chain imm", mk(8'h00, 0, 0, 1, 1, 0, 16'd10), 0, 32'h60, 1, 0, -1);
      run_op("R5 chain jump", mk(8'h00, 0, 0, 1, 0, 0, 16'd10), 1, 32'h60, 0, 0, -1);
      run_op("R11 chain lat0", mk(8'h00, 0, 0, 1, 0, 0, 16'd10), 0, 32'h60, 0, 0, -1);
      // R12: start pulsed while busy
      run_op("R12 poke", mk(8'h00, 0, 0, 0, 0, 0, 16'd40), 0, 32'h0, 6, 1, -1);

      // R8 R10: self-referencing chain, then abort
      begin
         int r0;
         mem[0] = mk(8'h00, 0, 0, 1, 0, 0, 16'd0);
         track = 1'b0;
         @(negedge clk);
         lat = 1; instr_word = mem[0]; is_jump = 1'b0; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         repeat (500) @(negedge clk);
         check("R8 busy", {31'd0, busy}, 1);
         tests++;
         if (reads < 100) begin
            fails++;
            $display("FAIL R8: %0d reads, expected at least 100", reads);
         end
         abort = 1'b1;
         @(negedge clk);
         abort = 1'b0;
         check("R10 busy", {31'd0, busy}, 0);
         check("R10 rd_en", {31'd0, mem_rd_en}, 0);
         r0 = reads;
         repeat (20) @(negedge clk);
         check("R10 no reads", reads - r0, 0);
         track = 1'b1;
      end
      // R10: normal operation after abort
      run_op("R10 after", mk(8'h00, 1, 0, 0, 1, 5, 16'hFFFF), 0, 32'h0, 0, 0, 2);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule